// File: doc/BRIEF.md
# Two-Wire Controlled Audio/Video Source Selector

This block is a write-only two-wire serial slave that receives one control byte and turns it into the control lines of a four-source audio/video switch. It oversamples the bus clock and data lines with a fast system clock. It recognises start and stop conditions and compares the incoming address with a fixed pattern whose low address bit comes from a strap pin. It acknowledges by enabling a pull-down on the data line.

The accepted byte is held in one control register. The register is decoded into a shared video/audio source select, a video gain select, a left/right routing for the two audio outputs, and two pull-down enables for open-drain port pins. An asynchronous reset clears the register. The reset state selects the tuner source, mutes the audio, sets the low gain and releases both port pins.

Top module: `av_switch_ctrl`

## Requirements
- R1: After reset the register is zero. vid_src and aud_src are 00, vid_gain_hi is 0, both audio routes are 00 (mute), port_pull is 00, and sda_oe is 0.
- R2: The slave acknowledges an address byte equal to {1,0,0,1,0,0,addr_strap,0}, sent MSB first. This is 0x90 with the strap low and 0x92 with the strap high. The acknowledge holds sda_oe high through the high phase of the ninth SCL clock.
- R3: An address byte that does not match, or that has its last bit (read/write) at 1, is not acknowledged. The bus is then ignored until the next start, and any following byte is neither acknowledged nor stored.
- R4: After an acknowledged address, a data byte is acknowledged and becomes the control register at its acknowledge. Bits [1:0] drive both vid_src and aud_src: 00 tuner, 01 input 2, 10 input 3, 11 input 4.
- R5: Data bit 3 drives vid_gain_hi (0 = 0 dB, 1 = 6 dB).
- R6: Data bits [7:6] set the audio routing. Each route output uses 00 for mute, 01 for the left channel of the selected source and 10 for its right channel. Mode 00 gives left=00 and right=00. Mode 01 gives left=10 and right=10. Mode 10 gives left=01 and right=01. Mode 11 gives left=01 and right=10.
- R7: port_pull[0] equals data bit 4 and port_pull[1] equals data bit 5. A 1 pulls its pin low and a 0 releases it high.
- R8: A stop or start that arrives partway through a data byte leaves the control register unchanged.
- R9: A start that arrives while a transfer is in progress restarts address reception, and a matching address after it is acknowledged.
- R10: Further data bytes before the stop are each acknowledged, and each one replaces the register in turn.
- R11: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| addr_strap | input | 1 | Strap setting the low address bit |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| vid_src | output | 2 | Video source select |
| aud_src | output | 2 | Audio source select |
| vid_gain_hi | output | 1 | Video gain: 1 = 6 dB, 0 = 0 dB |
| aud_l_route | output | 2 | Left output routing (00 mute, 01 left, 10 right) |
| aud_r_route | output | 2 | Right output routing (00 mute, 01 left, 10 right) |
| port_pull | output | 2 | Pull-down enables of the two port pins |

## Verification
The assertions check on every cycle that the control register changes only at the start of a data acknowledge, and that a stop always releases the data line and returns the slave to idle. They also check that a start always re-arms address reception at bit zero, that an address acknowledge follows only a matching write address, and that the pull-down never toggles while the synchronized clock is high. The bench scenarios are needed to show the bus-level behaviour that depends on the master's actions. These are the decoded routing for each mode, the effect of the strap, the refusal of reads and of foreign addresses, aborted bytes, repeated starts, and several data bytes in one transfer.

// File: rtl/av_switch_ctrl.sv
module av_switch_ctrl #(
  parameter logic [5:0] ADDR_HI = 6'b100100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       addr_strap,
  output logic       sda_oe,
  output logic [1:0] vid_src,
  output logic [1:0] aud_src,
  output logic       vid_gain_hi,
  output logic [1:0] aud_l_route,
  output logic [1:0] aud_r_route,
  output logic [1:0] port_pull
);
  localparam logic [1:0] RT_MUTE  = 2'b00;
  localparam logic [1:0] RT_LEFT  = 2'b01;
  localparam logic [1:0] RT_RIGHT = 2'b10;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_AACK, ST_DATA, ST_DACK} st_t;

  logic [2:0] scl_p, sda_p;
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       scl_rise, scl_fall, start_det, stop_det;
  st_t        state;
  logic [3:0] cnt;
  logic [7:0] shreg, ctrl;
  logic       addr_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end

  assign scl_s     = scl_p[1];
  assign scl_q     = scl_p[2];
  assign sda_s     = sda_p[1];
  assign sda_q     = sda_p[2];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign addr_ok   = (shreg == {ADDR_HI, addr_strap, 1'b0});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      ctrl   <= '0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_DATA: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (state == ST_DATA) begin
              ctrl   <= shreg;
              sda_oe <= 1'b1;
              state  <= ST_DACK;
            end else if (addr_ok) begin
              sda_oe <= 1'b1;
              state  <= ST_AACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK, ST_DACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_DATA;
          end
        end
        default: ;
      endcase
    end

  assign vid_src     = ctrl[1:0];
  assign aud_src     = ctrl[1:0];
  assign vid_gain_hi = ctrl[3];
  assign port_pull   = ctrl[5:4];
  assign aud_l_route = (ctrl[7:6] == 2'b00) ? RT_MUTE :
                       (ctrl[7:6] == 2'b01) ? RT_RIGHT : RT_LEFT;
  assign aud_r_route = (ctrl[7:6] == 2'b00) ? RT_MUTE :
                       (ctrl[7:6] == 2'b10) ? RT_LEFT : RT_RIGHT;

  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  assert_ctrl_at_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl != $past(ctrl)) |-> (state == ST_DACK && $rose(sda_oe)));

  assert_stop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe));

  assert_start_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR && cnt == 4'd0));

  assert_addr_ack_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && state == ST_AACK) |-> ($past(shreg) == {ADDR_HI, $past(addr_strap), 1'b0}));
endmodule

// File: tb/av_switch_ctrl_bench.sv
module av_switch_ctrl_bench;
  localparam int Q  = 40;
  localparam int NV = 10;
  // {strap, address byte, data byte}
  localparam logic [16:0] VECS [NV] = '{
    {1'b0, 8'h90, 8'hC0}, {1'b0, 8'h90, 8'h49}, {1'b0, 8'h90, 8'h92},
    {1'b0, 8'h92, 8'h3F}, {1'b1, 8'h92, 8'hFF}, {1'b1, 8'h90, 8'h00},
    {1'b1, 8'h93, 8'h00}, {1'b0, 8'h90, 8'h2B}, {1'b0, 8'h80, 8'h11},
    {1'b0, 8'h90, 8'hE6}};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe, vid_gain_hi;
  logic [1:0] vid_src, aud_src, aud_l_route, aud_r_route, port_pull;
  logic sda_line;
  int nchk = 0, nfail = 0, oe_bad = 0;
  logic prev_oe = 1'b0;
  logic [7:0] model = 8'h00;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  av_switch_ctrl u_av_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .addr_strap(strap),
    .sda_oe(sda_oe), .vid_src(vid_src), .aud_src(aud_src), .vid_gain_hi(vid_gain_hi),
    .aud_l_route(aud_l_route), .aud_r_route(aud_r_route), .port_pull(port_pull));

  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl_m) oe_bad++;
    prev_oe = sda_oe;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  function automatic logic [10:0] expect_out(logic [7:0] d);
    logic [1:0] l, r;
    case (d[7:6])
      2'b00: begin l = 2'b00; r = 2'b00; end
      2'b01: begin l = 2'b10; r = 2'b10; end
      2'b10: begin l = 2'b01; r = 2'b01; end
      default: begin l = 2'b01; r = 2'b10; end
    endcase
    return {d[1:0], d[1:0], d[3], l, r, d[5:4]};
  endfunction

  function automatic logic [10:0] dut_out();
    return {vid_src, aud_src, vid_gain_hi, aud_l_route, aud_r_route, port_pull};
  endfunction

  task automatic check_outs(string req);
    chk(req, {21'd0, dut_out()}, {21'd0, expect_out(model)});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic a1, a2;
    tick(5);
    chk("R1 reset outputs", {21'd0, dut_out()}, 32'd0);
    chk("R1 reset sda_oe", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    tick(10);

    for (int v = 0; v < NV; v++) begin
      logic exp_ack;
      strap = VECS[v][16];
      tick(Q);
      exp_ack = (VECS[v][15:8] == {6'b100100, VECS[v][16], 1'b0});
      bus_start();
      send_byte(VECS[v][15:8], a1);
      send_byte(VECS[v][7:0], a2);
      bus_stop();
      tick(Q);
      if (exp_ack) model = VECS[v][7:0];
      chk(exp_ack ? "R2 address ack" : "R3 address nack", {31'd0, a1}, {31'd0, exp_ack});
      chk(exp_ack ? "R4 data ack" : "R3 data ignored", {31'd0, a2}, {31'd0, exp_ack});
      check_outs("R4 R5 R6 R7 decoded outputs");
    end

    strap = 1'b0;
    bus_start(); send_byte(8'h90, a1); send_bits(8'h3C, 5); bus_stop(); tick(Q);
    chk("R8 stop mid-byte ack", {31'd0, a1}, 32'd1);
    check_outs("R8 stop mid-byte register kept");

    bus_start(); send_byte(8'h90, a1); send_bits(8'h55, 3);
    bus_start();
    check_outs("R8 start mid-byte register kept");
    send_byte(8'h90, a1);
    chk("R9 repeated start address ack", {31'd0, a1}, 32'd1);
    send_byte(8'h7D, a2); bus_stop(); tick(Q);
    model = 8'h7D;
    chk("R9 data after repeated start ack", {31'd0, a2}, 32'd1);
    check_outs("R9 data after repeated start");

    bus_start(); send_byte(8'hA0, a1);
    chk("R3 foreign address nack", {31'd0, a1}, 32'd0);
    bus_start(); send_byte(8'h90, a1);
    chk("R9 start after nack acked", {31'd0, a1}, 32'd1);
    send_byte(8'h41, a2);
    model = 8'h41;
    check_outs("R10 first byte committed");
    send_byte(8'hB8, a1);
    chk("R10 second byte ack", {31'd0, a1}, 32'd1);
    model = 8'hB8;
    check_outs("R10 second byte overwrites");
    send_byte(8'h13, a1); bus_stop(); tick(Q);
    model = 8'h13;
    check_outs("R10 third byte overwrites");

    chk("R11 sda_oe toggles with SCL high", oe_bad, 0);

    rst_n = 1'b0; tick(3);
    chk("R1 reset clears register", {21'd0, dut_out()}, 32'd0);
    rst_n = 1'b1; tick(3);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule